// File: doc/BRIEF.md
# Banked Parallel Scratchpad with Bank-Conflict Replay

This block is a 16 KB on-chip scratchpad shared by a group of parallel lanes. A request presents, for every lane, an active flag, a byte address, a write flag and 32 bits of write data. The store is divided into independent single-port banks, and consecutive 32-bit words go to consecutive banks. Lanes whose words sit in different banks are all served in the same pass.

When several active lanes need different words of the same bank, the request is split into serialized passes. In each pass, the lowest-numbered pending lane decides which word of its bank is accessed. Every other pending lane that wants that same word is served alongside it. Reads of one word are broadcast to all lanes that ask for it. Concurrent writes to one word keep the data of the highest-numbered lane.

While passes remain, the block holds its ready output low. When the last pass has come back, it raises a one-cycle done pulse together with the read data for every lane. A 32-lane group is issued as two 16-lane requests, one after the other.

Top module: `sps_scratchpad`

## Requirements
- R1: While reset is applied and in the first cycle after it, `req_ready` is 1 and `rsp_done` is 0.
- R2: A byte address maps to bank = address bits [5:2] and row = bits [13:6]. Bits [1:0] are ignored. A word that is written can be read back at the same word address.
- R3: A request needing a single pass is accepted at some clock edge. Its `rsp_done` is high in the cycle after the fourth following edge.
- R4: The pass count P is the largest number of distinct word addresses that the active lanes request from any one bank, with a minimum of 1. `rsp_done` is high in the cycle after edge 3+P, counting from the acceptance edge.
- R5: After acceptance, `req_ready` is 0 for P cycles and rises again after the edge that issues the final pass. A `req_valid` held high during that time starts no new request.
- R6: Active lanes that read the same word are served in one pass and all receive its contents.
- R7: When several active lanes write the same word in one request, the word ends up holding the data of the highest-numbered of those lanes.
- R8: A read of a word that is also written in the same request returns the contents the word had before the request.
- R9: Inactive lanes (`lane_valid` bit 0) change no memory word and add no passes, whatever their address, write flag and data.
- R10: In the `rsp_done` cycle, an active reading lane carries its word on `rsp_rdata`, and writing lanes and inactive lanes carry 0. `rsp_rdata` holds its value until the next `rsp_done`.
- R11: A request with no active lanes completes as a single pass, with `rsp_done` in the cycle after edge 4 and all-zero read data.
- R12: A new request may be accepted at the edge right after the final-pass edge of the previous request, and both requests complete correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Block can accept a request this cycle |
| lane_valid | input | 16 | Per-lane active flag |
| lane_we | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | 224 | Per-lane byte address, 14 bits per lane, lane 0 in the low bits |
| lane_wdata | input | 512 | Per-lane write data, 32 bits per lane, lane 0 in the low bits |
| rsp_done | output | 1 | One-cycle pulse: the request has completed |
| rsp_rdata | output | 512 | Per-lane read data, 32 bits per lane, lane 0 in the low bits |

## Verification
The bench builds the block with its default parameters: 16 lanes over 16 banks of 256 words each. This makes it cheap to fill the whole 4096-word store through the ports and to check every word against the bench's own model. Because there is one lane per bank, a single request can range from fully parallel up to the 16-pass worst case, where every lane targets a different word of one bank. Random requests confined to a few rows create heavy, mixed conflicts and broadcasts and are issued back to back. Each one is checked for data and for the completion cycle implied by its pass count.

// File: rtl/sps_pkg.sv
// Package: sps_pkg
// Shared default sizes for the banked scratchpad. The block assumes that the
// lane count, bank count and words per bank are powers of two.
package sps_pkg;
    localparam int unsigned SPS_LANES      = 16;
    localparam int unsigned SPS_BANKS      = 16;
    localparam int unsigned SPS_BANK_BYTES = 1024;
    localparam int unsigned SPS_DATA_W     = 32;
    localparam int unsigned SPS_PIPE_DEPTH = 3;  // edges from pass issue to done
endpackage

// File: rtl/sps_bank_arb.sv
// Module: sps_bank_arb
// Per-bank pass selector. Among the pending lanes that target this bank, the
// lowest-numbered one picks the row. All pending lanes asking for that row are
// served together. Reads are broadcast, and among the writers the data of the
// highest-numbered lane is kept.
// Assumes: lane_bank and lane_row are stable for the whole request.
module sps_bank_arb #(
    parameter int unsigned NUM_LANES = 16,
    parameter int unsigned BANK_W    = 4,
    parameter int unsigned ROW_W     = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BANK_ID   = 0
) (
    input  logic [NUM_LANES-1:0]             pend,
    input  logic [NUM_LANES-1:0][BANK_W-1:0] lane_bank,
    input  logic [NUM_LANES-1:0][ROW_W-1:0]  lane_row,
    input  logic [NUM_LANES-1:0]             lane_we,
    input  logic [NUM_LANES-1:0][DATA_W-1:0] lane_wdata,
    output logic [NUM_LANES-1:0]             served,
    output logic                             bank_en,
    output logic                             bank_we,
    output logic [ROW_W-1:0]                 bank_row,
    output logic [DATA_W-1:0]                bank_wdata
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_ID[BANK_W-1:0];

    logic [NUM_LANES-1:0] hit;
    logic                 found;

    // choose the winning row, the served lanes and the merged write
    always_comb begin
        found      = 1'b0;
        bank_row   = '0;
        served     = '0;
        bank_we    = 1'b0;
        bank_wdata = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            hit[i] = pend[i] && (lane_bank[i] == MY_BANK);
        end
        for (int i = 0; i < NUM_LANES; i++) begin
            if (hit[i] && !found) begin
                found    = 1'b1;
                bank_row = lane_row[i];
            end
        end
        for (int i = 0; i < NUM_LANES; i++) begin
            served[i] = found && hit[i] && (lane_row[i] == bank_row);
            if (served[i] && lane_we[i]) begin
                bank_we    = 1'b1;
                bank_wdata = lane_wdata[i];
            end
        end
        bank_en = found;
    end
endmodule

// File: rtl/sps_sram_bank.sv
// Module: sps_sram_bank
// One single-port bank. A read returns the contents from before a write to the
// same row in the same cycle. Read data comes out two edges after the access:
// the array read register, then an output register.
module sps_sram_bank #(
    parameter int unsigned ROWS   = 256,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rd_q;

    // array access: read old contents, then write
    always_ff @(posedge clk) begin
        if (en) begin
            rd_q <= mem[row];
            if (we) begin
                mem[row] <= wdata;
            end
        end
    end

    // output register stage of the bank
    always_ff @(posedge clk) begin
        dout <= rd_q;
    end
endmodule

// File: rtl/sps_scratchpad.sv
// Module: sps_scratchpad
// Banked scratchpad for a group of parallel lanes. An accepted request issues
// one pass per cycle until no lane is left pending. Every pass carries a tag
// down a three-stage return pipeline that gathers read data per lane. The
// final pass raises a one-cycle done pulse with the data of all lanes.
// Assumes: power-of-two lanes, banks and rows. Address = {row, bank, byte}.
module sps_scratchpad
    import sps_pkg::*;
#(
    parameter int unsigned NUM_LANES  = SPS_LANES,
    parameter int unsigned NUM_BANKS  = SPS_BANKS,
    parameter int unsigned BANK_BYTES = SPS_BANK_BYTES,
    parameter int unsigned DATA_W     = SPS_DATA_W,
    localparam int unsigned WORD_B    = DATA_W / 8,
    localparam int unsigned OFS_W     = $clog2(WORD_B),
    localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
    localparam int unsigned ROWS      = BANK_BYTES / WORD_B,
    localparam int unsigned ROW_W     = $clog2(ROWS),
    localparam int unsigned ADDR_W    = OFS_W + BANK_W + ROW_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [NUM_LANES-1:0]        lane_valid,
    input  logic [NUM_LANES-1:0]        lane_we,
    input  logic [NUM_LANES*ADDR_W-1:0] lane_addr,
    input  logic [NUM_LANES*DATA_W-1:0] lane_wdata,
    output logic                        rsp_done,
    output logic [NUM_LANES*DATA_W-1:0] rsp_rdata
);
    typedef logic [NUM_LANES-1:0][BANK_W-1:0] bank_vec_t;

    // request state
    logic                             busy;
    logic [NUM_LANES-1:0]             pend;
    bank_vec_t                        req_bank;
    logic [NUM_LANES-1:0][ROW_W-1:0]  req_row;
    logic [NUM_LANES-1:0]             req_we;
    logic [NUM_LANES-1:0]             req_rdm;
    logic [NUM_LANES-1:0][DATA_W-1:0] req_wdata;
    logic                             accept;
    logic [NUM_LANES-1:0]             grant;
    logic                             last_pass;

    // bank side
    logic [NUM_BANKS-1:0][NUM_LANES-1:0] served;
    logic [NUM_BANKS-1:0]                bank_en;
    logic [NUM_BANKS-1:0]                bank_we;
    logic [NUM_BANKS-1:0][ROW_W-1:0]     bank_row;
    logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_wdata;
    logic [NUM_BANKS-1:0][DATA_W-1:0]    bank_dout;

    // return pipeline tags
    logic                             t1_v, t2_v, t3_v;
    logic                             t1_last, t2_last, t3_last;
    logic [NUM_LANES-1:0]             t1_grant, t2_grant;
    logic [NUM_LANES-1:0]             t1_rdm, t2_rdm, t3_rdm;
    bank_vec_t                        t1_bank, t2_bank;
    logic [NUM_LANES-1:0][DATA_W-1:0] coll;

    logic unused_ofs;

    assign req_ready = !busy;
    assign accept    = req_valid && !busy;

    // the byte offset inside a word selects nothing
    always_comb begin
        unused_ofs = 1'b0;
        for (int l = 0; l < NUM_LANES; l++) begin
            unused_ofs = unused_ofs ^ (^lane_addr[l*ADDR_W +: OFS_W]);
        end
    end

    // control: load pending lanes on acceptance, retire granted lanes per pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pend <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            pend <= lane_valid;
        end else if (busy) begin
            pend <= pend & ~grant;
            if (last_pass) begin
                busy <= 1'b0;
            end
        end
    end

    // capture the per-lane request fields at acceptance
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                req_bank[l]  <= lane_addr[l*ADDR_W + OFS_W +: BANK_W];
                req_row[l]   <= lane_addr[l*ADDR_W + OFS_W + BANK_W +: ROW_W];
                req_we[l]    <= lane_we[l];
                req_rdm[l]   <= lane_valid[l] && !lane_we[l];
                req_wdata[l] <= lane_wdata[l*DATA_W +: DATA_W];
            end
        end
    end

    // one selector and one array per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sps_bank_arb #(
            .NUM_LANES(NUM_LANES),
            .BANK_W   (BANK_W),
            .ROW_W    (ROW_W),
            .DATA_W   (DATA_W),
            .BANK_ID  (b)
        ) arb_i (
            .pend      (pend),
            .lane_bank (req_bank),
            .lane_row  (req_row),
            .lane_we   (req_we),
            .lane_wdata(req_wdata),
            .served    (served[b]),
            .bank_en   (bank_en[b]),
            .bank_we   (bank_we[b]),
            .bank_row  (bank_row[b]),
            .bank_wdata(bank_wdata[b])
        );

        sps_sram_bank #(
            .ROWS  (ROWS),
            .DATA_W(DATA_W)
        ) ram_i (
            .clk  (clk),
            .en   (bank_en[b]),
            .we   (bank_we[b]),
            .row  (bank_row[b]),
            .wdata(bank_wdata[b]),
            .dout (bank_dout[b])
        );

        // R9: arrays are written only while a request is being replayed
        // R9
        bank_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_en[b] && bank_we[b] |-> busy);
    end

    // merge the lanes served by all banks into this pass's grant
    always_comb begin
        grant = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            grant = grant | served[b];
        end
        last_pass = ((pend & ~grant) == '0);
    end

    // return stage 1 and 2: tags travel alongside the bank read pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1_v <= 1'b0;
            t2_v <= 1'b0;
        end else begin
            t1_v <= busy;
            t2_v <= t1_v;
        end
        t1_last  <= last_pass;
        t1_grant <= grant;
        t1_rdm   <= req_rdm;
        t1_bank  <= req_bank;
        t2_last  <= t1_last;
        t2_grant <= t1_grant;
        t2_rdm   <= t1_rdm;
        t2_bank  <= t1_bank;
    end

    // return stage 3: steer each bank's word to the lanes served in that pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t3_v <= 1'b0;
        end else begin
            t3_v <= t2_v;
        end
        t3_last <= t2_last;
        t3_rdm  <= t2_rdm;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (t2_v && t2_grant[l]) begin
                coll[l] <= bank_dout[t2_bank[l]];
            end
        end
    end

    // completion: pulse done and present read lanes, zero for others
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= t3_v && t3_last;
            if (t3_v && t3_last) begin
                for (int l = 0; l < NUM_LANES; l++) begin
                    rsp_rdata[l*DATA_W +: DATA_W] <= t3_rdm[l] ? coll[l] : '0;
                end
            end
        end
    end

    // R5
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R4
    pend_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (pend != '0) |=> $countones(pend) < $past($countones(pend)));

    // R9
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0);

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R1
    idle_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pend == '0));
endmodule

// File: tb/sps_scratchpad_tb_top.sv
// Scoreboard bench: the driver task models each request, pushes the expected
// completion cycle and data, and a monitor pops and compares on every done.
module sps_scratchpad_tb_top;
    localparam int NL = 16;
    localparam int AW = 14;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [NL-1:0]     lane_valid = '0;
    logic [NL-1:0]     lane_we = '0;
    logic [NL*AW-1:0]  lane_addr;
    logic [NL*DW-1:0]  lane_wdata;
    logic              rsp_done;
    logic [NL*DW-1:0]  rsp_rdata;

    logic [AW-1:0] la  [NL];
    logic [DW-1:0] lwd [NL];

    logic [DW-1:0] mdl [4096];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_err = 0;
    int            ex_cyc [$];
    logic [NL*DW-1:0] ex_dat [$];
    string         ex_tag [$];
    logic [NL*DW-1:0] last_rd = '0;
    bit            ended = 1'b0;
    int unsigned   seed = 32'h2468_ACE1;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            lane_addr[i*AW +: AW]  = la[i];
            lane_wdata[i*DW +: DW] = lwd[i];
        end
    end

    sps_scratchpad dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .lane_valid(lane_valid),
        .lane_we   (lane_we),
        .lane_addr (lane_addr),
        .lane_wdata(lane_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata)
    );

    task automatic chk(bit ok, string req, string what, logic [NL*DW-1:0] act,
                       logic [NL*DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic logic [AW-1:0] mk(int row, int bank, int ofs);
        return {row[7:0], bank[3:0], ofs[1:0]};
    endfunction

    // drive one request, model it, queue the expectation, check ready timing
    task automatic send(string tag, bit hold);
        int p;
        int acc;
        bit rdy_ok;
        logic [NL*DW-1:0] exp;
        p = 0;
        for (int b = 0; b < 16; b++) begin
            int cnt;
            cnt = 0;
            for (int i = 0; i < NL; i++) begin
                if (lane_valid[i] && la[i][5:2] == b[3:0]) begin
                    bit seen;
                    seen = 1'b0;
                    for (int j = 0; j < i; j++) begin
                        if (lane_valid[j] && la[j][13:2] == la[i][13:2]) seen = 1'b1;
                    end
                    if (!seen) cnt++;
                end
            end
            if (cnt > p) p = cnt;
        end
        if (p == 0) p = 1;
        exp = '0;
        for (int i = 0; i < NL; i++) begin
            if (lane_valid[i] && !lane_we[i]) exp[i*DW +: DW] = mdl[la[i][13:2]];
        end
        for (int i = 0; i < NL; i++) begin
            if (lane_valid[i] && lane_we[i]) mdl[la[i][13:2]] = lwd[i];
        end
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        acc = cyc;
        ex_cyc.push_back(acc + 3 + p);
        ex_dat.push_back(exp);
        ex_tag.push_back(tag);
        if (!hold) req_valid = 1'b0;
        rdy_ok = 1'b1;
        @(negedge clk);
        while (cyc < acc + p) begin
            if (req_ready !== 1'b0) rdy_ok = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R5: ready low through the replay window
        chk(rdy_ok, "R5", "ready low while passes remain", '0, '0);
        // R5 R12: ready back high right after the final pass
        chk(req_ready === 1'b1, "R5 R12", "ready after final pass",
            {{(NL*DW-1){1'b0}}, req_ready}, 1);
    endtask

    task automatic idle_lanes();
        lane_valid = '0;
        lane_we = '0;
        for (int i = 0; i < NL; i++) begin
            la[i] = '0;
            lwd[i] = '0;
        end
    endtask

    // monitor: pop and compare on each completion pulse
    always @(negedge clk) begin
        if (rst_n && rsp_done && !ended) begin
            if (ex_cyc.size() == 0) begin
                chk(1'b0, "R5", "done with no request outstanding", '0, '0);
            end else begin
                int ec;
                logic [NL*DW-1:0] ed;
                string et;
                ec = ex_cyc.pop_front();
                ed = ex_dat.pop_front();
                et = ex_tag.pop_front();
                // R3 R4: completion cycle follows the pass count
                chk(cyc == ec, {et, " R4"}, "done cycle", NL*DW'(cyc), NL*DW'(ec));
                // R10: per-lane read data
                chk(rsp_rdata === ed, {et, " R10"}, "read data", rsp_rdata, ed);
            end
            last_rd = rsp_rdata;
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle_lanes();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1 && rsp_done === 1'b0, "R1", "in reset",
            {rsp_done, req_ready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && rsp_done === 1'b0, "R1", "after reset",
            {rsp_done, req_ready}, 2'b01);

        // R2 R10: fill every word, one conflict-free row per request
        for (int r = 0; r < 256; r++) begin
            lane_valid = '1;
            lane_we = '1;
            for (int i = 0; i < NL; i++) begin
                la[i]  = mk(r, i, 0);
                lwd[i] = ((r * 16 + i) * 32'h0101_0101) ^ 32'hC0DE_0000;
            end
            send("R2 fill", 1'b0);
        end

        // R3 R2: one pass, lanes reversed over banks, byte offsets set
        idle_lanes();
        lane_valid = '1;
        for (int i = 0; i < NL; i++) la[i] = mk(7, 15 - i, i);
        send("R3 R2", 1'b0);

        // R4: every lane in bank 5, distinct rows -> 16 passes
        for (int i = 0; i < NL; i++) la[i] = mk(i * 3, 5, 0);
        send("R4 worst", 1'b0);

        // R6: all lanes read one word
        for (int i = 0; i < NL; i++) la[i] = mk(9, 2, i);
        send("R6 broadcast", 1'b0);

        // R4 R6: two words of bank 3, each broadcast -> 2 passes
        for (int i = 0; i < NL; i++) la[i] = mk(10 + i / 8, 3, 0);
        send("R4 R6 pair", 1'b0);

        // R7: three writers on one word, then read it back
        idle_lanes();
        lane_valid = 16'h0824;
        lane_we    = 16'h0824;
        for (int i = 0; i < NL; i++) begin
            la[i]  = mk(20, 4, 0);
            lwd[i] = 32'hABC0_0000 + i;
        end
        send("R7 write", 1'b0);
        lane_we = '0;
        lane_valid = 16'h0001;
        send("R7 readback", 1'b0);

        // R8: read and write of one word in the same request
        idle_lanes();
        lane_valid = 16'h000B;
        lane_we    = 16'h0002;
        for (int i = 0; i < NL; i++) la[i] = mk(30, 6, 0);
        lwd[1] = 32'h5EED_F00D;
        send("R8 mixed", 1'b0);
        lane_we = '0;
        send("R8 readback", 1'b0);

        // R9: only lane 0 active, the others are writes to distinct rows of bank 0
        idle_lanes();
        lane_valid = 16'h0001;
        lane_we    = 16'hFFFE;
        for (int i = 0; i < NL; i++) begin
            la[i]  = mk(40 + i, 0, 0);
            lwd[i] = 32'hDEAD_0000 + i;
        end
        send("R9 inactive", 1'b0);
        lane_valid = '1;
        lane_we    = '0;
        send("R9 readback", 1'b0);

        // R11: no active lanes
        idle_lanes();
        send("R11 empty", 1'b0);

        // R5: valid held high through four passes
        lane_valid = 16'h000F;
        for (int i = 0; i < NL; i++) la[i] = mk(50 + i, 8, 0);
        send("R5 hold", 1'b1);

        // R10: data held between completions
        idle_lanes();
        repeat (8) @(negedge clk);
        chk(rsp_rdata === last_rd, "R10", "read data held", rsp_rdata, last_rd);

        // R12 R4: random back-to-back requests in a few rows
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NL; i++) begin
                int unsigned v;
                v = rnd();
                lane_valid[i] = (v[3:0] != 0);
                lane_we[i]    = v[4] & v[5];
                la[i]         = mk(v[7:6], v[11:8], v[13:12]);
                lwd[i]        = rnd();
            end
            send("R12 random", 1'b0);
        end

        idle_lanes();
        for (int k = 0; k < 200 && ex_cyc.size() != 0; k++) @(negedge clk);
        chk(ex_cyc.size() == 0, "R4", "all requests completed",
            NL*DW'(ex_cyc.size()), '0);
        finish_run();
    end
endmodule